// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the bus-write latch of a small NOR-style flash model. It takes one latched write per `wr_valid` pulse and works out the command the host is sending. It recognises unlock sequences, moves between the device modes, and hands a single-byte program request to a separate program controller. The controller answers with a done or a fail pulse. The sequencer never checks whether any data bits change; it only follows the controller's verdict.

Each of the eight equal blocks has a protection bit. The block is picked by the three top address bits. A program aimed at a protected block is dropped here, before it reaches the controller. For a bus read, the block reports where the data should come from: the array, an identification code, or status. In identification mode it also supplies the code byte itself.

An unlock sequence is three writes:

1. AAh to address 5555h.
2. 55h to address 2AAAh.
3. A command byte to 5555h.

Only the low 15 address bits take part in these comparisons. The bypass mode cuts a program down to two writes, so a programmer that streams many bytes spends less time on the bus.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (read-array), `rd_src` is 0 (array) and `prog_req` is low.
- R2: The unlock sequence with command 90h sets `mode` to 1 (auto-select) and `rd_src` to 1 (code). Reads do not change this mode; only a later write does.
- R3: In auto-select, `rd_code` depends on `rd_addr[1:0]`:
  - 00 gives 20h.
  - 01 gives 20h.
  - 10 gives 01h when the block selected by `rd_addr[16:14]` has its `prot_bits` bit set, and 00h when it does not.
  - 11 gives 00h.
- R4: The unlock sequence with command A0h, followed by a fourth write of any address and data (F0h included), has these effects when the fourth write's block is unprotected:
  - `prog_req` is high for exactly one cycle, in the cycle after that write.
  - `prog_addr` and `prog_data` carry that write's address and data.
  - `mode` becomes 2 (busy) and `rd_src` becomes 2 (status).
- R5: A program write, whether from the four-write or the two-write bypass form, that falls in a protected block raises no `prog_req`. The mode then returns to 0, or stays at 4 for the bypass form.
- R6: While `mode` is 2 or 5, every write is ignored: `mode` holds and no `prog_req` appears.
- R7: A `prog_done` pulse in mode 2 returns `mode` to 0. A `prog_fail` pulse in mode 2 or 5 sets `mode` to 3 (error) with `rd_src` 2. The error mode stays in place through any write that is not a reset.
- R8: A reset is either a single write of F0h to any address, or the unlock sequence with F0h as the command. Either form clears mode 3 to mode 0, and either form also leaves mode 1 for mode 0.
- R9: A write that breaks the unlock sequence returns the block to mode 0 with the sequence cleared, from mode 0 or from mode 1. A full sequence issued right afterwards is accepted.
- R10: The unlock sequence with command 20h sets `mode` to 4 (unlock-bypass) with `rd_src` 0. In mode 4, a write of A0h followed by one address/data write raises `prog_req` and sets `mode` to 5. A `prog_done` pulse then returns `mode` to 4.
- R11: In mode 4, writes other than A0h and 90h change nothing. A 90h write followed by 00h returns to mode 0. A 90h write followed by any other byte stays in mode 4.
- R12: When the error came from a bypass program, a reset write returns `mode` to 4, not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| wr_valid | input | 1 | One-cycle strobe: a latched bus write is present |
| wr_addr | input | 17 | Address of the latched write |
| wr_data | input | 8 | Data of the latched write |
| rd_addr | input | 17 | Address of the current bus read |
| prot_bits | input | 8 | Protection flag per block; bit n covers the block with address bits [16:14] = n |
| prog_done | input | 1 | Program controller finished successfully |
| prog_fail | input | 1 | Program controller finished with an error |
| prog_req | output | 1 | One-cycle request to start a program |
| prog_addr | output | 17 | Address to program, valid with `prog_req` |
| prog_data | output | 8 | Byte to program, valid with `prog_req` |
| mode | output | 3 | 0 read-array, 1 auto-select, 2 busy, 3 error, 4 unlock-bypass, 5 bypass busy |
| rd_src | output | 2 | Read source: 0 array, 1 code, 2 status |
| rd_code | output | 8 | Identification or protection byte in auto-select, else 00h |

## Verification
The sequencer is driven with several kinds of write sequence:

- Complete unlock sequences with each command byte.
- Sequences broken at the first cycle and at the command cycle, which show that a broken sequence resets the step count as well as the mode.
- Program writes to a protected and an unprotected block, with data F0h in the program cycle, which shows that reset decoding does not take over a program byte.
- Writes during the busy window, which show that they are ignored.

A done or a fail is injected after both program forms, which separates the return to read-array from the return to bypass. Resets are issued in both the single-write and the three-write form. The auto-select reads cover all four low-address codes on a protected and an unprotected block.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_ASEL  = 3'd1,
    MD_BUSY  = 3'd2,
    MD_ERR   = 3'd3,
    MD_BYP   = 3'd4,
    MD_BBUSY = 3'd5
  } fcs_mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_CODE   = 2'd1,
    RS_STATUS = 2'd2
  } fcs_rsrc_e;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_BYPEXIT = 8'h00;
endpackage

// File: rtl/fcs_block_prot.sv
module fcs_block_prot #(
  parameter int ADDR_W   = 17,
  parameter int BLK_BITS = 3,
  localparam int NBLK    = 1 << BLK_BITS
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_bits,
  output logic              wr_prot,
  output logic              rd_prot
);
  logic [NBLK-1:0] wsel;
  logic [NBLK-1:0] rsel;

  // One decoder per block; protection is the OR of selected flags.
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign wsel[b] = (wr_addr[ADDR_W-1 -: BLK_BITS] == BLK_BITS'(b));
    assign rsel[b] = (rd_addr[ADDR_W-1 -: BLK_BITS] == BLK_BITS'(b));
  end

  assign wr_prot = |(wsel & prot_bits);
  assign rd_prot = |(rsel & prot_bits);
endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h20
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        rd_low,
  input  logic              rd_prot,
  output logic [1:0]        rd_src,
  output logic [DATA_W-1:0] rd_code
);
  always_comb begin
    case (mode)
      MD_ASEL:                  rd_src = RS_CODE;
      MD_BUSY, MD_BBUSY, MD_ERR: rd_src = RS_STATUS;
      default:                  rd_src = RS_ARRAY;
    endcase
  end

  always_comb begin
    rd_code = '0;
    if (mode == MD_ASEL) begin
      case (rd_low)
        2'b00:   rd_code = DATA_W'(MFR_CODE);
        2'b01:   rd_code = DATA_W'(DEV_CODE);
        2'b10:   rd_code = DATA_W'(rd_prot);
        default: rd_code = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcs_mode_fsm.sv
module fcs_mode_fsm
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SEQ_ADDR_W = 15,
  parameter logic [SEQ_ADDR_W-1:0] UNLOCK_ADDR1 = 15'h5555,
  parameter logic [SEQ_ADDR_W-1:0] UNLOCK_ADDR2 = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_prot,
  input  logic              prog_done,
  input  logic              prog_fail,
  output logic [2:0]        mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  fcs_mode_e   mode_q, mode_d;
  logic [1:0]  step_q, step_d;
  logic        errbyp_q, errbyp_d;
  logic        req_q, req_d;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  fcs_mode_e   brk_mode;
  logic        at_a1, at_a2;

  assign at_a1 = (wr_addr[SEQ_ADDR_W-1:0] == UNLOCK_ADDR1);
  assign at_a2 = (wr_addr[SEQ_ADDR_W-1:0] == UNLOCK_ADDR2);
  // A broken sequence keeps a pending error, otherwise lands in read-array.
  assign brk_mode = (mode_q == MD_ERR) ? MD_ERR : MD_READ;

  always_comb begin
    mode_d   = mode_q;
    step_d   = step_q;
    errbyp_d = errbyp_q;
    req_d    = 1'b0;
    case (mode_q)
      MD_READ, MD_ASEL, MD_ERR: begin
        if (wr_valid) begin
          step_d = 2'd0;
          if (step_q == 2'd3) begin
            if (wr_prot) mode_d = MD_READ;
            else begin
              req_d  = 1'b1;
              mode_d = MD_BUSY;
            end
          end else if (wr_data == DATA_W'(CMD_RESET)) begin
            mode_d   = (mode_q == MD_ERR && errbyp_q) ? MD_BYP : MD_READ;
            errbyp_d = 1'b0;
          end else begin
            case (step_q)
              2'd0: if (at_a1 && wr_data == DATA_W'(CMD_UNLOCK1)) step_d = 2'd1;
                    else mode_d = brk_mode;
              2'd1: if (at_a2 && wr_data == DATA_W'(CMD_UNLOCK2)) step_d = 2'd2;
                    else mode_d = brk_mode;
              default: begin
                if (at_a1 && mode_q != MD_ERR && wr_data == DATA_W'(CMD_IDENT))
                  mode_d = MD_ASEL;
                else if (at_a1 && mode_q != MD_ERR && wr_data == DATA_W'(CMD_PROG))
                  step_d = 2'd3;
                else if (at_a1 && mode_q != MD_ERR && wr_data == DATA_W'(CMD_BYPASS))
                  mode_d = MD_BYP;
                else
                  mode_d = brk_mode;
              end
            endcase
          end
        end
      end
      MD_BUSY, MD_BBUSY: begin
        step_d = 2'd0;
        if (prog_fail) begin
          mode_d   = MD_ERR;
          errbyp_d = (mode_q == MD_BBUSY);
        end else if (prog_done) begin
          mode_d = (mode_q == MD_BBUSY) ? MD_BYP : MD_READ;
        end
      end
      MD_BYP: begin
        if (wr_valid) begin
          case (step_q)
            2'd0: begin
              if (wr_data == DATA_W'(CMD_PROG))       step_d = 2'd1;
              else if (wr_data == DATA_W'(CMD_IDENT)) step_d = 2'd2;
            end
            2'd1: begin
              step_d = 2'd0;
              if (!wr_prot) begin
                req_d  = 1'b1;
                mode_d = MD_BBUSY;
              end
            end
            default: begin
              step_d = 2'd0;
              if (step_q == 2'd2 && wr_data == DATA_W'(CMD_BYPEXIT)) mode_d = MD_READ;
            end
          endcase
        end
      end
      default: begin
        mode_d = MD_READ;
        step_d = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_READ;
      step_q   <= 2'd0;
      errbyp_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      step_q   <= step_d;
      errbyp_q <= errbyp_d;
      req_q    <= req_d;
    end
  end

  // Request payload is loaded only when a request is issued.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (req_d) begin
      paddr_q <= wr_addr;
      pdata_q <= wr_data;
    end
  end

  assign mode      = mode_q;
  assign prog_req  = req_q;
  assign prog_addr = paddr_q;
  assign prog_data = pdata_q;

  assert_req_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (mode_q == MD_BUSY || mode_q == MD_BBUSY));
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BUSY && !prog_done && !prog_fail) |=> (mode_q == MD_BUSY && !req_q));
  assert_fail_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_BUSY || mode_q == MD_BBUSY) && prog_fail) |=> (mode_q == MD_ERR));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ERR && !wr_valid) |=> (mode_q == MD_ERR));
  assert_byp_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BBUSY && prog_done && !prog_fail) |=> (mode_q == MD_BYP));
  assert_byp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BYP && !wr_valid) |=> (mode_q == MD_BYP));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int BLK_BITS = 3,
  localparam int NBLK    = 1 << BLK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_bits,
  input  logic              prog_done,
  input  logic              prog_fail,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [2:0]        mode,
  output logic [1:0]        rd_src,
  output logic [DATA_W-1:0] rd_code
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       wr_prot;
  logic       rd_prot;
  logic [ADDR_W-3:0] unused_rd_mid;

  // Reset asserts at once and is released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];
  assign unused_rd_mid = rd_addr[ADDR_W-1:2];

  fcs_block_prot #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_prot (
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .prot_bits(prot_bits),
    .wr_prot  (wr_prot),
    .rd_prot  (rd_prot)
  );

  fcs_mode_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_prot  (wr_prot),
    .prog_done(prog_done),
    .prog_fail(prog_fail),
    .mode     (mode),
    .prog_req (prog_req),
    .prog_addr(prog_addr),
    .prog_data(prog_data)
  );

  fcs_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .mode   (mode),
    .rd_low (rd_addr[1:0]),
    .rd_prot(rd_prot),
    .rd_src (rd_src),
    .rd_code(rd_code)
  );
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  prot_bits = 8'b0000_0100;
  logic        prog_done = 1'b0;
  logic        prog_fail = 1'b0;
  logic        prog_req;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  mode;
  logic [1:0]  rd_src;
  logic [7:0]  rd_code;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .prot_bits(prot_bits),
    .prog_done(prog_done), .prog_fail(prog_fail), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .mode(mode),
    .rd_src(rd_src), .rd_code(rd_code)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, cmd);
  endtask

  task automatic pulse(input bit fail);
    @(negedge clk);
    if (fail) prog_fail = 1'b1; else prog_done = 1'b1;
    @(negedge clk);
    prog_fail = 1'b0; prog_done = 1'b0;
  endtask

  task automatic rd_code_at(input logic [16:0] a, input logic [7:0] exp, input string what);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(what, rd_code, exp);
  endtask

  task automatic t_reset;
    chk("R1 mode after reset", mode, 0);
    chk("R1 rd_src after reset", rd_src, 0);
    chk("R1 prog_req after reset", prog_req, 0);
  endtask

  task automatic t_asel;
    unlock(8'h90);
    chk("R2 mode auto-select", mode, 1);
    chk("R2 rd_src code", rd_src, 1);
    rd_code_at(17'h00000, 8'h20, "R3 maker code");
    rd_code_at(17'h00001, 8'h20, "R3 device code");
    rd_code_at(17'h08002, 8'h01, "R3 protected block");
    rd_code_at(17'h0C002, 8'h00, "R3 unprotected block");
    rd_code_at(17'h00003, 8'h00, "R3 low bits 11");
    chk("R2 mode held over reads", mode, 1);
    wr(17'h01234, 8'h12);
    chk("R9 break from auto-select", mode, 0);
  endtask

  task automatic t_prog;
    unlock(8'hA0);
    wr(17'h10123, 8'h5A);
    chk("R4 prog_req", prog_req, 1);
    chk("R4 prog_addr", prog_addr, 17'h10123);
    chk("R4 prog_data", prog_data, 8'h5A);
    chk("R4 mode busy", mode, 2);
    chk("R4 rd_src status", rd_src, 2);
    @(negedge clk);
    chk("R4 prog_req single cycle", prog_req, 0);
    wr(17'h05555, 8'hAA);
    chk("R6 busy ignores write", mode, 2);
    wr(17'h00000, 8'hF0);
    chk("R6 busy ignores reset", mode, 2);
    chk("R6 no request in busy", prog_req, 0);
    pulse(0);
    chk("R7 done returns read", mode, 0);
    unlock(8'hA0);
    wr(17'h00044, 8'hF0);
    chk("R4 F0 as program data", prog_req, 1);
    chk("R4 F0 data value", prog_data, 8'hF0);
    pulse(0);
  endtask

  task automatic t_prot;
    unlock(8'hA0);
    wr(17'h08010, 8'h77);
    chk("R5 protected no request", prog_req, 0);
    chk("R5 protected back to read", mode, 0);
  endtask

  task automatic t_fail;
    unlock(8'hA0);
    wr(17'h00010, 8'h01);
    pulse(1);
    chk("R7 fail gives error", mode, 3);
    chk("R7 error reads status", rd_src, 2);
    wr(17'h01234, 8'h12);
    chk("R7 error sticky", mode, 3);
    wr(17'h1FFFF, 8'hF0);
    chk("R8 single-write reset", mode, 0);
    unlock(8'hA0);
    wr(17'h00011, 8'h02);
    pulse(1);
    unlock(8'hF0);
    chk("R8 three-write reset", mode, 0);
    unlock(8'h90);
    wr(17'h00000, 8'hF0);
    chk("R8 reset leaves auto-select", mode, 0);
  endtask

  task automatic t_break;
    wr(17'h05555, 8'hAA);
    wr(17'h01111, 8'h55);
    chk("R9 break at second write", mode, 0);
    unlock(8'h90);
    chk("R9 sequence after break", mode, 1);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h77);
    chk("R9 bad command byte", mode, 0);
    unlock(8'h90);
    chk("R9 step count cleared", mode, 1);
    wr(17'h00000, 8'hF0);
  endtask

  task automatic t_byp;
    unlock(8'h20);
    chk("R10 bypass mode", mode, 4);
    chk("R10 bypass reads array", rd_src, 0);
    wr(17'h00000, 8'hA0);
    wr(17'h00200, 8'h33);
    chk("R10 bypass request", prog_req, 1);
    chk("R10 bypass addr", prog_addr, 17'h00200);
    chk("R10 bypass data", prog_data, 8'h33);
    chk("R10 bypass busy", mode, 5);
    wr(17'h00000, 8'hA0);
    chk("R6 bypass busy ignores write", mode, 5);
    pulse(0);
    chk("R10 done returns bypass", mode, 4);
    wr(17'h00005, 8'h12);
    chk("R11 other write ignored", mode, 4);
    wr(17'h05555, 8'hF0);
    chk("R11 F0 ignored in bypass", mode, 4);
    wr(17'h00000, 8'hA0);
    wr(17'h09000, 8'h44);
    chk("R5 bypass protected no request", prog_req, 0);
    chk("R5 bypass protected stays", mode, 4);
    wr(17'h00000, 8'h90);
    wr(17'h00000, 8'h55);
    chk("R11 90 then non-00 stays", mode, 4);
    wr(17'h00000, 8'h90);
    wr(17'h00000, 8'h00);
    chk("R11 bypass exit", mode, 0);
  endtask

  task automatic t_bypfail;
    unlock(8'h20);
    wr(17'h00000, 8'hA0);
    wr(17'h00300, 8'h0F);
    pulse(1);
    chk("R12 bypass fail error", mode, 3);
    wr(17'h00000, 8'hF0);
    chk("R12 reset back to bypass", mode, 4);
    wr(17'h00000, 8'h90);
    wr(17'h00000, 8'h00);
    chk("R12 exit after recovery", mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_asel();
    t_prog();
    t_prot();
    t_fail();
    t_break();
    t_byp();
    t_bypfail();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule